// File: doc/BRIEF.md
# SHA-512 Message Block Padder

This block sits in front of a SHA-512 or SHA-384 compression core. It takes a message one byte at a time and packs the bytes into 1024-bit blocks. Each time a block fills, the block is offered to the core. When the producer marks the end of the message, the block appends the standard message padding. The padding is a single 0x80 marker, then a run of zero bytes, then a 128-bit big-endian count of message bits. The padding always finishes exactly on a block boundary. The core sees a stream of complete blocks and a flag on the last one, and never has to handle partial data or length arithmetic itself.

The bit count is a 128-bit counter made of two halves, with a carry from the low half into the high half. Padding bytes are generated inside the block and do not add to the count. When the message ends 112 or more bytes into a block, the marker and the length field do not fit, so one extra block is emitted. While a filled block waits for the core, the input is stalled. An init pulse drops any partially assembled message and restarts the count.

Top module: `msg_block_padder`

## Requirements
- R1: After reset or an `init` pulse, the fill level and both halves of the bit count are zero, `in_ready` is high and `blk_valid` is low.
- R2: Byte number n of a block (n = 0 for the first accepted byte) appears on `blk_data[1023-8n -: 8]`, so the earliest byte is the most significant.
- R3: `blk_valid` rises once 128 bytes have been placed in the buffer. It then stays high, with `blk_data` unchanged, until a cycle in which `blk_ready` is high.
- R4: `in_ready` is low in every cycle in which `blk_valid` is high.
- R5: The first padding byte is 0x80, written right after the last message byte. It is followed by `(111 - u) & 127` zero bytes, where u is the fill level just before the 0x80 byte is written.
- R6: The last 16 bytes of the final block carry the bit count: the high half first, then the low half, each most-significant byte first. The count is 8 per accepted message byte and excludes all padding.
- R7: Each accepted byte adds 8 to the low half of the count. When the low half wraps past its width (`LEN_LO_W` bits), the high half increments by one.
- R8: A message whose length modulo 128 is 112 or more ends in two padded blocks, otherwise in one. `blk_final` is high only on the last block of a message, and padding never spills past it.
- R9: A transfer with `in_keep` low stores no byte and adds nothing to the count. Combined with `in_last`, such a transfer ends the message, so an empty message is sent as a single transfer with `in_keep` low and `in_last` high.
- R10: An `init` pulse in the middle of a message discards the bytes already taken. The next message is then padded and counted as if it were the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| init | input | 1 | Synchronous restart: drops the partial message and clears the count |
| in_valid | input | 1 | Producer offers a transfer |
| in_ready | output | 1 | Block accepts a transfer this cycle |
| in_byte | input | 8 | Message byte |
| in_keep | input | 1 | The transfer carries a byte in `in_byte` |
| in_last | input | 1 | This transfer ends the message |
| blk_valid | output | 1 | A complete 1024-bit block is offered |
| blk_ready | input | 1 | Core takes the offered block |
| blk_data | output | 1024 | Block contents, first byte in the top bits |
| blk_final | output | 1 | The offered block is the last one of the message |

## Verification
The hardest condition to reach from the ports is a carry from the low half of the bit count into the high half. With a 64-bit low half, that needs about 2^61 bytes. To reach it, the bench runs a second copy of the block with `LEN_LO_W` set to 12, fed with the same stimulus. A 600-byte message then wraps the low half once, and the length field of that copy must show a high half of 1 and a low half of 704. Lengths of 111 and 112 bytes, and 127 and 128 bytes, fall on either side of the point where padding needs an extra block. These are sent as directed cases, with random backpressure on `blk_ready`, so a final block can be held while the padder is stalled.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_PAD   = 2'd1,
    ST_FLUSH = 2'd2
  } pad_state_e;

  // Zero bytes placed between the 0x80 marker and the length field, given
  // the fill level before the marker. blk must be a power of two; the
  // length field takes blk/8 bytes.
  function automatic int unsigned zero_run(int unsigned used, int unsigned blk);
    return (blk - (blk / 8) - 1 - used) & (blk - 1);
  endfunction

endpackage

// File: rtl/pad_len_counter.sv
module pad_len_counter #(
  parameter int HI_W = 64,
  parameter int LO_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  output logic [HI_W-1:0] hi_q,
  output logic [LO_W-1:0] lo_q
);

  logic [LO_W-1:0] lo_sum;
  logic            lo_carry;

  assign {lo_carry, lo_sum} = {1'b0, lo_q} + (LO_W + 1)'(8);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (inc) begin
      lo_q <= lo_sum;
      hi_q <= hi_q + HI_W'(lo_carry);
    end
  end

  // R7
  carry_into_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (lo_q[LO_W-1:3] == '1)) |=> (hi_q == $past(hi_q) + HI_W'(1)));

  // R7
  no_spurious_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (lo_q[LO_W-1:3] != '1)) |=> $stable(hi_q));

endmodule

// File: rtl/pad_block_buffer.sv
module pad_block_buffer #(
  parameter int BLK_BYTES = 128,
  localparam int FILL_W = $clog2(BLK_BYTES + 1),
  localparam int DATA_W = BLK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [7:0]        wr_byte,
  input  logic              take,
  output logic [DATA_W-1:0] data_q,
  output logic [FILL_W-1:0] fill_q,
  output logic              full
);

  logic [31:0] wr_lsb;

  assign full   = (fill_q == FILL_W'(BLK_BYTES));
  assign wr_lsb = (32'(BLK_BYTES) - 32'd1 - 32'(fill_q)) << 3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      data_q <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (take && full) begin
      fill_q <= '0;
    end else if (wr_en && !full) begin
      data_q[wr_lsb +: 8] <= wr_byte;
      fill_q <= fill_q + FILL_W'(1);
    end
  end

  // R4
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(BLK_BYTES));

endmodule

// File: rtl/pad_sequencer.sv
module pad_sequencer
  import sha_pad_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int HI_W = 64,
  parameter int LO_W = 64,
  localparam int FILL_W = $clog2(BLK_BYTES + 1),
  localparam int FIELD_B = BLK_BYTES / 8,
  localparam int HALF_W = FIELD_B * 4,
  localparam int CNT_W = $clog2(2 * BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [FILL_W-1:0] fill,
  input  logic [HI_W-1:0]   len_hi,
  input  logic [LO_W-1:0]   len_lo,
  output logic [7:0]        pad_byte,
  output logic              pad_last
);

  logic [CNT_W-1:0]    k_q;
  logic [CNT_W-1:0]    total_q;
  logic [CNT_W-1:0]    total_now;
  logic [CNT_W-1:0]    len_start;
  logic [CNT_W-1:0]    field_idx;
  logic [2*HALF_W-1:0] field;
  logic [2*HALF_W-1:0] field_sh;

  // Total pad bytes is decided when the marker goes out and held after.
  assign total_now = (k_q == '0)
    ? CNT_W'(FIELD_B + 1 + zero_run(32'(fill), BLK_BYTES))
    : total_q;
  assign len_start = total_now - CNT_W'(FIELD_B);
  assign field_idx = k_q - len_start;
  assign field     = {HALF_W'(len_hi), HALF_W'(len_lo)};
  assign field_sh  = field << {field_idx, 3'b000};
  assign pad_last  = (k_q == total_now - CNT_W'(1));

  always_comb begin
    if (k_q == '0)
      pad_byte = 8'h80;
    else if (k_q >= len_start)
      pad_byte = field_sh[2*HALF_W-1 -: 8];
    else
      pad_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      k_q     <= '0;
      total_q <= '0;
    end else if (step) begin
      if (k_q == '0)
        total_q <= total_now;
      k_q <= pad_last ? '0 : k_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/msg_block_padder.sv
module msg_block_padder
  import sha_pad_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int LEN_HI_W = 64,
  parameter int LEN_LO_W = 64,
  localparam int DATA_W = BLK_BYTES * 8,
  localparam int FILL_W = $clog2(BLK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic              in_keep,
  input  logic              in_last,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [DATA_W-1:0] blk_data,
  output logic              blk_final
);

  pad_state_e            st_q;
  logic                  full;
  logic [FILL_W-1:0]     fill;
  logic [LEN_HI_W-1:0]   len_hi;
  logic [LEN_LO_W-1:0]   len_lo;
  logic [7:0]            pad_byte;
  logic                  pad_last;

  // Named internal events
  logic accept;
  logic data_wr;
  logic pad_step;
  logic take;
  logic msg_end;
  logic final_take;

  assign in_ready   = (st_q == ST_LOAD) && !full;
  assign accept     = in_valid && in_ready;
  assign data_wr    = accept && in_keep;
  assign msg_end    = accept && in_last;
  assign pad_step   = (st_q == ST_PAD) && !full;
  assign take       = full && blk_ready;
  assign final_take = take && (st_q == ST_FLUSH);
  assign blk_valid  = full;
  assign blk_final  = (st_q == ST_FLUSH);

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      st_q <= ST_LOAD;
    end else begin
      unique case (st_q)
        ST_LOAD:  if (msg_end) st_q <= ST_PAD;
        ST_PAD:   if (pad_step && pad_last) st_q <= ST_FLUSH;
        ST_FLUSH: if (take) st_q <= ST_LOAD;
        default:  st_q <= ST_LOAD;
      endcase
    end
  end

  pad_block_buffer #(.BLK_BYTES(BLK_BYTES)) buf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (init),
    .wr_en   (data_wr || pad_step),
    .wr_byte (pad_step ? pad_byte : in_byte),
    .take    (take),
    .data_q  (blk_data),
    .fill_q  (fill),
    .full    (full)
  );

  pad_len_counter #(.HI_W(LEN_HI_W), .LO_W(LEN_LO_W)) len_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (init || final_take),
    .inc   (data_wr),
    .hi_q  (len_hi),
    .lo_q  (len_lo)
  );

  pad_sequencer #(.BLK_BYTES(BLK_BYTES), .HI_W(LEN_HI_W), .LO_W(LEN_LO_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (init || msg_end),
    .step     (pad_step),
    .fill     (fill),
    .len_hi   (len_hi),
    .len_lo   (len_lo),
    .pad_byte (pad_byte),
    .pad_last (pad_last)
  );

  // R3
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready && !init) |=> (blk_valid && $stable(blk_data)));

  // R8
  pad_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_step && pad_last) |-> (fill == FILL_W'(BLK_BYTES - 1)));

  // R6
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_PAD) && !init) |=> ($stable(len_hi) && $stable(len_lo)));

  // R8
  final_has_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_final |-> blk_valid);

  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (in_ready && !blk_valid && (len_hi == '0) && (len_lo == '0)));

endmodule

// File: tb/msg_block_padder_tb_top.sv
module msg_block_padder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_keep = 1'b0;
  logic in_last = 1'b0;
  logic blk_ready = 1'b0;

  logic in_ready, blk_valid, blk_final;
  logic [1023:0] blk_data;
  logic in_ready_c, blk_valid_c, blk_final_c;
  logic [1023:0] blk_data_c;

  always #4 clk = ~clk;

  msg_block_padder dut_i (
    .clk(clk), .rst_n(rst_n), .init(init),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .in_keep(in_keep), .in_last(in_last),
    .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_data(blk_data), .blk_final(blk_final)
  );

  msg_block_padder #(.LEN_LO_W(12)) dut_c_i (
    .clk(clk), .rst_n(rst_n), .init(init),
    .in_valid(in_valid), .in_ready(in_ready_c), .in_byte(in_byte),
    .in_keep(in_keep), .in_last(in_last),
    .blk_valid(blk_valid_c), .blk_ready(blk_ready),
    .blk_data(blk_data_c), .blk_final(blk_final_c)
  );

  int n_checks = 0;
  int n_fails = 0;
  int cycles = 0;
  logic [7:0] msg [0:1023];
  int msg_len = 0;
  int nblk = 0;
  int bi = 0;
  bit skip_cmp = 1'b0;
  bit prev_hold = 1'b0;
  logic [1023:0] prev_data = '0;

  task automatic check(input bit ok, input string req, input logic [1023:0] act,
                       input logic [1023:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int total_bytes(input int len);
    return ((len + 17 + 127) / 128) * 128;
  endfunction

  // Expected contents of block number b for a copy whose low count half is w bits.
  function automatic logic [1023:0] exp_block(input int b, input int w);
    logic [127:0] bits, hi, lo, field;
    logic [1023:0] blk;
    int tot;
    bits = 128'(msg_len) * 128'd8;
    hi = bits >> w;
    lo = bits & ((128'd1 << w) - 128'd1);
    field = {hi[63:0], lo[63:0]};
    tot = total_bytes(msg_len);
    blk = '0;
    for (int n = 0; n < 128; n++) begin
      int p;
      logic [7:0] v;
      p = b * 128 + n;
      if (p < msg_len) v = msg[p];
      else if (p == msg_len) v = 8'h80;
      else if (p >= tot - 16) v = field[127 - 8 * (p - (tot - 16)) -: 8];
      else v = 8'h00;
      blk[1023 - 8 * n -: 8] = v;
    end
    return blk;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung actual=%0d expected<150000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  // Block collector with random backpressure.
  initial begin
    bit r;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_hold)  // R3
          check(blk_valid && (blk_data == prev_data), "R3 held block", blk_data, prev_data);
        if (blk_valid)  // R4
          check(!in_ready, "R4 input stalled", 1024'(in_ready), 1024'd0);
        r = ($urandom % 4) != 0;
        blk_ready = r;
        prev_hold = blk_valid && !r && !init;
        prev_data = blk_data;
        if (blk_valid && r) begin
          if (!skip_cmp) begin
            // R2 R5 R6: byte order, marker, zero run and length field
            check(blk_data == exp_block(bi, 64), "R2 R5 R6 block contents", blk_data, exp_block(bi, 64));
            // R7: narrow-count copy sees the carry in its high half
            check(blk_data_c == exp_block(bi, 12), "R7 narrow count block", blk_data_c, exp_block(bi, 12));
            // R8
            check(blk_final == (bi == nblk - 1), "R8 final flag", 1024'(blk_final), 1024'(bi == nblk - 1));
          end
          bi++;
        end
      end
    end
  end

  task automatic xfer(input logic [7:0] b, input bit k, input bit l);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte = b;
    in_keep = k;
    in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_last = 1'b0;
    if (($urandom % 5) == 0) @(negedge clk);
  endtask

  // R9: bubbles with in_keep low are mixed in and must leave no trace.
  task automatic send_msg(input int len, input bit bubbles);
    msg_len = len;
    nblk = total_bytes(len) / 128;
    bi = 0;
    for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
    if (len == 0) begin
      xfer(8'h5a, 1'b0, 1'b1);
    end else begin
      for (int i = 0; i < len; i++) begin
        if (bubbles && (($urandom % 7) == 0)) xfer(8'hff, 1'b0, 1'b0);
        xfer(msg[i], 1'b1, i == len - 1);
      end
    end
    while (bi < nblk) @(negedge clk);
    repeat (3) @(negedge clk);
    // R8: block count of the padded message
    check(bi == nblk, "R8 block count", 1024'(bi), 1024'(nblk));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(in_ready && !blk_valid, "R1 reset state", {in_ready, blk_valid}, 2'b10);

    // Directed boundary lengths (R5 R8), R9 empty message via keep low
    send_msg(0, 1'b0);
    send_msg(111, 1'b0);
    send_msg(112, 1'b0);
    send_msg(127, 1'b1);
    send_msg(128, 1'b1);

    // R7: 600 bytes wraps a 12-bit low half once (hi=1, lo=704)
    send_msg(600, 1'b1);

    // R10: abandoned partial message, then init
    skip_cmp = 1'b1;
    for (int i = 0; i < 60; i++) xfer(8'($urandom), 1'b1, 1'b0);
    @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    // R1 after init
    check(in_ready && !blk_valid, "R1 state after init", {in_ready, blk_valid}, 2'b10);
    skip_cmp = 1'b0;
    send_msg(20, 1'b0);  // R10: padded as a fresh message

    // Constrained random lengths
    for (int t = 0; t < 6; t++) send_msg(int'($urandom % 400), 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule